// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets logic running on a single clock read and write an external asynchronous static RAM that stores 2^18 words of 16 bits and can enable each byte lane on its own. A client hands over one access at a time through a valid/ready handshake. Each access carries a word address, a direction flag, write data and a two-bit lane mask. The controller turns the access into the active-low strobes the memory expects: chip select, output enable, write strobe and one enable per byte lane. It also drives the address bus and controls the bus driver for the shared data lines. The data lines are split into an outgoing value, a drive enable and an incoming value, so the pad ring can build the tristate buffer.

Every access starts with an address-setup phase in which only the chip select and the lane enables are active. A write then holds the write strobe low for a fixed number of clocks, and the controller drives the data bus only inside that window. The strobe rises while the data is still being driven, which gives the data its setup time to the edge that ends the write. A read instead lowers the output enable for a fixed number of clocks and samples the bus on the last of them. The captured word is returned one clock later, with a one-clock valid pulse. Phase lengths are computed at elaboration from nanosecond timing parameters and the clock period, and each is rounded up to whole clocks. With the defaults (5 ns clock) the setup phase is 1 clock, the write pulse is 2 clocks and the read access is 1 clock. Between accesses the chip select stays high, so the memory sits in its low-power deselected state.

Top module: `asram_bridge`

## Requirements
- R1: While no access is in progress, req_ready is 1. In that state ce_n, oe_n and we_n are 1, both bits of be_n are 1 and dq_oe is 0.
- R2: A synchronous active-high reset returns the block to the idle state of R1 at the next clock edge, abandoning any access in progress. No response is produced for an abandoned access.
- R3: A request is taken at a clock edge where req_valid and req_ready are both 1. From the next cycle on, mem_addr shows the request address and ce_n is 0 for the whole access. The address stays unchanged while ce_n is 0. The setup phase lasts 1 clock with the defaults, and during it oe_n and we_n are 1.
- R4: For a write, we_n is 0 for exactly 2 clocks (default) right after the setup phase, and ce_n stays 0 throughout. mem_dq_o holds the request data during those clocks. The controller is idle again in the cycle after we_n rises.
- R5: dq_oe is 1 only in cycles where we_n is 0 and oe_n is 1. we_n and oe_n are never 0 in the same cycle.
- R6: For a read, oe_n is 0 for 1 clock (default) right after the setup phase. we_n stays 1 during the read, and the data bus is sampled on the last clock of that phase.
- R7: One clock after the read phase ends, rsp_valid is 1 for exactly one cycle. rsp_rdata bits 7:0 hold the sampled bus bits 7:0 if mask bit 0 was 1, and 0 otherwise. Bits 15:8 hold bus bits 15:8 if mask bit 1 was 1, and 0 otherwise.
- R8: Every read is followed by one turnaround cycle. In that cycle all strobes are inactive and req_ready is 0, so a following request is taken at the earliest one clock later.
- R9: During an access, be_n[0] (bits 7:0) equals the inverse of mask bit 0, and be_n[1] (bits 15:8) equals the inverse of mask bit 1. A write therefore changes only the bytes whose mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte-lane mask, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| mem_addr | output | 18 | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | 2 | Byte-lane enables, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
A wrong phase or counter value shows up on the strobe pins within the same access. The effect is a write pulse that is too short or too long, an output enable that opens while the controller drives the bus, or a missing turnaround cycle. The per-clock comparison against the reference catches each of these in the first cycle it occurs. A wrong lane or data register shows up more slowly. It appears only when the corrupted byte is read back, so the bench follows masked writes with full-width reads of the same addresses. Stuck or misrouted capture logic shows up in the rsp_rdata of the very next read.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int LANES   = 2;
    localparam int LANE_W  = 8;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int ADDR_W  = 18;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_WPULSE = 3'd2,
        PH_RACC   = 3'd3,
        PH_TURN   = 3'd4
    } phase_e;

    // Registered pin bundle toward the memory.
    typedef struct packed {
        logic             ce_n;
        logic             oe_n;
        logic             we_n;
        logic [LANES-1:0] be_n;
        logic             drive;
    } pins_t;

    localparam pins_t PINS_OFF = pins_t'({3'b111, {LANES{1'b1}}, 1'b0});

    // Latched request attributes that steer the sequence.
    typedef struct packed {
        logic             wr;
        logic [LANES-1:0] mask;
    } op_t;

    // Round a time up to whole clocks, never below a floor.
    function automatic int ns_to_cyc(int t_ns, int clk_ns, int floor_cyc);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < floor_cyc) c = floor_cyc;
        return c;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Pin values belonging to each phase.
    function automatic pins_t pins_for(phase_e ph, logic [LANES-1:0] mask);
        pins_t p;
        p = PINS_OFF;
        case (ph)
            PH_SETUP: begin
                p.ce_n = 1'b0;
                p.be_n = ~mask;
            end
            PH_WPULSE: begin
                p.ce_n  = 1'b0;
                p.we_n  = 1'b0;
                p.be_n  = ~mask;
                p.drive = 1'b1;
            end
            PH_RACC: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
                p.be_n = ~mask;
            end
            default: p = PINS_OFF;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int CNT_W = 2,
    parameter int S_LEN = 1,
    parameter int W_LEN = 2,
    parameter int A_LEN = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              req_ready,
    input  logic              ph_last,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_len,
    output logic              cap_stb,
    output pins_t             pins_q,
    output logic [AW-1:0]     addr_q,
    output logic [WORD_W-1:0] wdata_q,
    output logic [LANES-1:0]  mask_q
);
    phase_e ph_q, ph_d;
    op_t    op_q, op_nx;
    logic   accept;
    pins_t  pins_d;

    assign req_ready = (ph_q == PH_IDLE);
    assign accept    = req_ready && req_valid;
    assign mask_q    = op_q.mask;

    always_comb begin
        ph_d     = ph_q;
        cnt_load = 1'b0;
        cnt_len  = '0;
        cap_stb  = 1'b0;
        case (ph_q)
            PH_IDLE: if (req_valid) begin
                ph_d     = PH_SETUP;
                cnt_load = 1'b1;
                cnt_len  = CNT_W'(S_LEN);
            end
            PH_SETUP: if (ph_last) begin
                cnt_load = 1'b1;
                if (op_q.wr) begin
                    ph_d    = PH_WPULSE;
                    cnt_len = CNT_W'(W_LEN);
                end else begin
                    ph_d    = PH_RACC;
                    cnt_len = CNT_W'(A_LEN);
                end
            end
            PH_WPULSE: if (ph_last) ph_d = PH_IDLE;
            PH_RACC: if (ph_last) begin
                ph_d    = PH_TURN;
                cap_stb = 1'b1;
            end
            PH_TURN: ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    always_comb begin
        op_nx = op_q;
        if (accept) begin
            op_nx.wr   = req_write;
            op_nx.mask = req_mask;
        end
        pins_d = pins_for(ph_d, op_nx.mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            pins_q  <= PINS_OFF;
            op_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            ph_q   <= ph_d;
            pins_q <= pins_d;
            op_q   <= op_nx;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap
    import asram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_stb,
    input  logic [LANES-1:0]  mask,
    input  logic [WORD_W-1:0] dq_i,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata
);
    logic [LANE_W-1:0] lane_q [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                lane_q[i] <= '0;
            else if (cap_stb)
                lane_q[i] <= mask[i] ? dq_i[i*LANE_W +: LANE_W] : '0;
        end
        assign rsp_rdata[i*LANE_W +: LANE_W] = lane_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_valid <= 1'b0;
        else     rsp_valid <= cap_stb;
    end

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge
    import asram_pkg::*;
#(
    parameter int CLK_NS      = 5,
    parameter int ASETUP_NS   = 0,
    parameter int WPULSE_NS   = 7,
    parameter int DSETUP_NS   = 5,
    parameter int ACCESS_NS   = 10,
    parameter int OE_ACC_NS   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [WORD_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [WORD_W-1:0] mem_dq_i
);
    localparam int SU_CYC = ns_to_cyc(ASETUP_NS, CLK_NS, 1);
    localparam int WP_CYC = ns_to_cyc(max2(WPULSE_NS, DSETUP_NS), CLK_NS, 1);
    localparam int RA_CYC = max2(ns_to_cyc(OE_ACC_NS, CLK_NS, 1),
                                 ns_to_cyc(ACCESS_NS, CLK_NS, 1) - SU_CYC);
    localparam int MAX_CYC = max2(SU_CYC, max2(WP_CYC, RA_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic              cnt_load, ph_last, cap_stb;
    logic [CNT_W-1:0]  cnt_len;
    pins_t             pins;
    logic [LANES-1:0]  mask_q;

    asram_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (cnt_load),
        .len  (cnt_len),
        .last (ph_last)
    );

    asram_seq #(
        .AW   (ADDR_W),
        .CNT_W(CNT_W),
        .S_LEN(SU_CYC),
        .W_LEN(WP_CYC),
        .A_LEN(RA_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_mask (req_mask),
        .req_ready(req_ready),
        .ph_last  (ph_last),
        .cnt_load (cnt_load),
        .cnt_len  (cnt_len),
        .cap_stb  (cap_stb),
        .pins_q   (pins),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_o),
        .mask_q   (mask_q)
    );

    asram_rdcap u_cap (
        .clk      (clk),
        .rst      (rst),
        .cap_stb  (cap_stb),
        .mask     (mask_q),
        .dq_i     (mem_dq_i),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    assign mem_ce_n  = pins.ce_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_be_n  = pins.be_n;
    assign mem_dq_oe = pins.drive;

endmodule

// File: rtl/asram_chk.sv
module asram_chk #(
    parameter int AW     = 18,
    parameter int DW     = 16,
    parameter int NL     = 2,
    parameter int WP_CYC = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [NL-1:0] mem_be_n,
    input logic [DW-1:0] mem_dq_o,
    input logic          mem_dq_oe
);
    logic [15:0] we_low_cnt;

    always_ff @(posedge clk) begin
        if (rst)            we_low_cnt <= '0;
        else if (!mem_we_n) we_low_cnt <= we_low_cnt + 16'd1;
        else                we_low_cnt <= '0;
    end

    AST_BUS_SAFE: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (mem_oe_n && !mem_we_n)); // R5
    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n); // R5
    AST_IDLE_PWRDN: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && (&mem_be_n) && !mem_dq_oe)); // R1
    AST_WE_IN_CE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce_n); // R4
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R3
    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_o)); // R4
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R7
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!req_ready && mem_ce_n)); // R8
    AST_WPULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_we_n) && !$past(rst)) |-> (we_low_cnt == 16'(WP_CYC))); // R4

endmodule

bind asram_bridge asram_chk #(
    .AW(asram_pkg::ADDR_W), .DW(asram_pkg::WORD_W), .NL(asram_pkg::LANES), .WP_CYC(WP_CYC)
) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_asram_bridge.sv
`timescale 1ns/1ps
module sim_asram_bridge;
    localparam int S = 1, W = 2, A = 1;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
    logic [17:0] mem_addr;
    logic [1:0]  mem_be_n;

    int n_chk = 0, n_fail = 0;
    bit armed = 0, done = 0;

    always #2.5 clk = ~clk;

    asram_bridge u0 (.*);

    // ---- behavioural memory on the pins ----
    logic [15:0] mem [int];
    logic [15:0] gold [int];

    function automatic logic [15:0] pat(int a);
        return 16'((a * 40503) ^ 16'h1357);
    endfunction
    function automatic logic [15:0] mget(int a);
        return mem.exists(a) ? mem[a] : pat(a);
    endfunction
    function automatic logic [15:0] gget(int a);
        return gold.exists(a) ? gold[a] : pat(a);
    endfunction

    always_comb begin
        logic [15:0] w;
        w = mget(int'(mem_addr));
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_i = {mem_be_n[1] ? 8'hC3 : w[15:8], mem_be_n[0] ? 8'hC3 : w[7:0]};
        else
            mem_dq_i = 16'h3C3C;
    end

    logic        p_ce = 1, p_we = 1;
    logic [1:0]  p_be = 2'b11;
    logic [15:0] p_dq = 0;
    logic [17:0] p_ad = 0;
    always @(negedge clk) begin
        if (!p_ce && !p_we && (mem_we_n || mem_ce_n)) begin
            logic [15:0] w;
            w = mget(int'(p_ad));
            if (!p_be[0]) w[7:0]  = p_dq[7:0];
            if (!p_be[1]) w[15:8] = p_dq[15:8];
            mem[int'(p_ad)] = w;
        end
        p_ce = mem_ce_n; p_we = mem_we_n; p_be = mem_be_n;
        p_dq = mem_dq_o; p_ad = mem_addr;
    end

    // ---- cycle reference model ----
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    int          m_mode = 0, m_k = 0;   // 0 idle,1 read,2 write,3 turn
    logic [17:0] m_addr;
    logic [15:0] m_data, m_rd;
    logic [1:0]  m_mask;
    bit          m_after_rst = 1;

    always @(posedge clk) if (rst) armed <= 1;

    always @(negedge clk) if (armed && !done) begin
        logic e_ce, e_oe, e_we, e_drv, e_rdy, e_rv;
        logic [1:0] e_be;
        string tg;
        e_ce = 1; e_oe = 1; e_we = 1; e_drv = 0; e_rdy = 0; e_rv = 0; e_be = 2'b11;
        case (m_mode)
            0: begin e_rdy = 1; tg = m_after_rst ? "R2" : "R1"; end
            1: begin e_ce = 0; e_be = ~m_mask; if (m_k >= S) e_oe = 0; tg = "R6"; end
            2: begin e_ce = 0; e_be = ~m_mask; if (m_k >= S) begin e_we = 0; e_drv = 1; end tg = "R4"; end
            default: begin e_rv = 1; tg = "R8"; end
        endcase
        chk(tg, {31'd0, mem_ce_n}, {31'd0, e_ce});
        chk(tg, {31'd0, mem_oe_n}, {31'd0, e_oe});
        chk(tg, {31'd0, mem_we_n}, {31'd0, e_we});
        chk("R9", {30'd0, mem_be_n}, {30'd0, e_be});
        chk("R5", {31'd0, mem_dq_oe}, {31'd0, e_drv});
        chk("R3", {31'd0, req_ready}, {31'd0, e_rdy});
        chk("R7", {31'd0, rsp_valid}, {31'd0, e_rv});
        if (!e_ce) chk("R3", {14'd0, mem_addr}, {14'd0, m_addr});
        if (e_drv) chk("R4", {16'd0, mem_dq_o}, {16'd0, m_data});
        if (e_rv)  chk("R7", {16'd0, rsp_rdata}, {16'd0, m_rd});
        // advance to the next cycle
        if (rst) begin
            m_mode = 0; m_after_rst = 1;
        end else begin
            m_after_rst = 0;
            case (m_mode)
                0: if (req_valid) begin
                    m_mode = req_write ? 2 : 1; m_k = 0;
                    m_addr = req_addr; m_data = req_wdata; m_mask = req_mask;
                    if (req_write) begin
                        logic [15:0] g;
                        g = gget(int'(req_addr));
                        if (req_mask[0]) g[7:0]  = req_wdata[7:0];
                        if (req_mask[1]) g[15:8] = req_wdata[15:8];
                        gold[int'(req_addr)] = g;
                    end else begin
                        logic [15:0] g;
                        g = gget(int'(req_addr));
                        m_rd = {req_mask[1] ? g[15:8] : 8'h00, req_mask[0] ? g[7:0] : 8'h00};
                    end
                end
                1: begin m_k++; if (m_k == S + A) m_mode = 3; end
                2: begin m_k++; if (m_k == S + W) m_mode = 0; end
                default: m_mode = 0;
            endcase
        end
    end

    // ---- stimulus ----
    task automatic issue(bit wr, int a, logic [15:0] d, logic [1:0] m);
        req_write = wr; req_addr = 18'(a); req_wdata = d; req_mask = m; req_valid = 1;
        forever begin
            @(negedge clk);
            if (req_ready) begin @(posedge clk); #1; break; end
        end
        req_valid = 0;
    endtask
    task automatic gap(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        gap(3);                                     // R1 idle, R2 after reset
        issue(1, 5, 16'h1234, 2'b11); gap(1);
        issue(0, 5, 0, 2'b11);        gap(2);
        issue(1, 6, 16'hABCD, 2'b01); gap(1);       // R9 lower only
        issue(0, 6, 0, 2'b11);        gap(1);
        issue(1, 7, 16'h9F8E, 2'b10);               // R9 upper only
        issue(0, 7, 0, 2'b11);
        issue(1, 8, 16'hFFFF, 2'b00);               // R9 no lanes
        issue(0, 8, 0, 2'b11);
        issue(0, 5, 0, 2'b01);                      // R7 masked reads
        issue(0, 5, 0, 2'b10);
        issue(0, 5, 0, 2'b00);
        issue(1, 9, 16'h0F0F, 2'b11);               // R8 read->write turn
        issue(0, 9, 0, 2'b11);
        issue(0, 9, 0, 2'b11);
        issue(1, 9, 16'h7777, 2'b11);
        // R2: reset during a read
        req_write = 0; req_addr = 18'd5; req_mask = 2'b11; req_valid = 1;
        forever begin
            @(negedge clk);
            if (req_ready) begin @(posedge clk); #1; break; end
        end
        req_valid = 0; rst = 1;
        gap(1); rst = 0;
        gap(2);
        issue(0, 9, 0, 2'b11);
        for (int i = 0; i < 400; i++) begin
            issue(1'($urandom), int'($urandom_range(0, 31)), 16'($urandom), 2'($urandom));
            gap(int'($urandom_range(0, 2)));
        end
        for (int a = 0; a < 32; a++) issue(0, a, 0, 2'b11);
        gap(4);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            finish_run();
        end
    end

endmodule